// File: doc/BRIEF.md
# Receive Command Word Generator

This block turns a requested receive length into the command words that an I2C controller needs before it will clock in that many bytes. One receive command covers at most 256 bytes. A longer read is therefore split into several commands. Each command is a 16-bit word that holds a fixed receive opcode and a byte count minus one. The words leave on a valid/ready stream, one per handshake, and go to the controller's command FIFO.

A start pulse captures the length. The number of words the sequence will produce is reported from the next cycle on. The block then presents the words in order and pulses done once the last word has been accepted. A request for zero bytes produces no words. It finishes at once and flags an error.

Top module: `rx_cmd_gen`

## Requirements
- R1: Every word presented with `m_valid_o` high has bits 10:8 equal to 001 and bits 15:11 equal to zero.
- R2: From the cycle after an accepted start, `word_count_o` equals N/256 rounded up, and it holds that value until the next accepted start.
- R3: Every word of a sequence except the last has bits 7:0 equal to 255.
- R4: The last word of a sequence has bits 7:0 equal to the remaining byte count minus one. For N of 256 or less, the sequence is a single word whose bits 7:0 equal N-1.
- R5: While `m_valid_o` is high and `m_ready_i` is low, the next cycle still has `m_valid_o` high and `m_data_o` unchanged.
- R6: `done_o` is high for exactly one cycle, namely the cycle after the last word's handshake. In that cycle `m_valid_o` and `busy_o` are low.
- R7: An accepted start with N equal to 0 emits no word. `done_o` pulses in the next cycle, `word_count_o` reads 0, and `err_o` rises and stays high until the next accepted start.
- R8: A start pulse while `busy_o` is high has no effect: the word sequence and `word_count_o` are those of the earlier request.
- R9: After reset, `m_valid_o`, `done_o`, `err_o` and `busy_o` are low and `word_count_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse; `len_i` is sampled with it |
| len_i | input | 16 | Total receive length in bytes |
| busy_o | output | 1 | A sequence is being emitted |
| word_count_o | output | 9 | Number of command words for the last accepted request |
| m_valid_o | output | 1 | Command word available |
| m_ready_i | input | 1 | Downstream accepts the word |
| m_data_o | output | 16 | Command word: opcode in bits 10:8, count-minus-one in bits 7:0 |
| done_o | output | 1 | One-cycle pulse when a request has finished |
| err_o | output | 1 | Last accepted request asked for zero bytes |

## Verification
The hardest situation to reach is a start pulse that arrives in the middle of a multi-word sequence while the downstream is stalling. That is where a faulty design would reload its remaining count or its word count and so corrupt the words still pending. The bench raises start with a fresh random length after the first handshake of multi-word requests and keeps ready random at several duty levels. It then compares every accepted word and the final count against the original request. The lengths around the chunk boundaries (1, 255, 256, 257, 512, 513) and the maximum length of 65535 are driven directly.

// File: rtl/rx_cmd_pkg.sv
package rx_cmd_pkg;
  localparam int unsigned OP_W    = 3;
  localparam logic [OP_W-1:0] OP_RECV = 3'b001;

  typedef enum logic {
    ST_IDLE,
    ST_SEND
  } gen_state_t;
endpackage

// File: rtl/rx_cmd_chunker.sv
// Holds the remaining length minus one and slices it into capped chunks.
module rx_cmd_chunker #(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             step_i,
  output logic [PAY_W-1:0] payload_o,
  output logic             last_o
);
  localparam logic [LEN_W-1:0] CHUNK = LEN_W'(1) << PAY_W;

  logic [LEN_W-1:0] rem_m1_q;
  logic [LEN_W-1:0] rem_m1_d;
  logic             rem_en;

  assign last_o    = (rem_m1_q[LEN_W-1:PAY_W] == '0);
  assign payload_o = last_o ? rem_m1_q[PAY_W-1:0] : {PAY_W{1'b1}};

  always_comb begin
    rem_en   = load_i | step_i;
    rem_m1_d = rem_m1_q;
    if (load_i) begin
      rem_m1_d = len_i - LEN_W'(1);
    end else if (step_i) begin
      rem_m1_d = last_o ? '0 : (rem_m1_q - CHUNK);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_m1_q <= '0;
    end else if (rem_en) begin
      rem_m1_q <= rem_m1_d;
    end
  end
endmodule

// File: rtl/rx_cmd_word_fmt.sv
// Packs opcode and payload into the output word, zero padding above.
module rx_cmd_word_fmt #(
  parameter int unsigned PAY_W  = 8,
  parameter int unsigned WORD_W = 16
) (
  input  logic [PAY_W-1:0]  payload_i,
  output logic [WORD_W-1:0] word_o
);
  import rx_cmd_pkg::*;
  localparam int unsigned PAD_W = WORD_W - OP_W - PAY_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign word_o = {{PAD_W{1'b0}}, OP_RECV, payload_i};
    end else begin : g_nopad
      assign word_o = {OP_RECV, payload_i};
    end
  endgenerate
endmodule

// File: rtl/rx_cmd_ctrl.sv
// Sequencing: accepts requests, tracks the stream, flags finish and error.
module rx_cmd_ctrl #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             len_zero_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             hs_i,
  input  logic             last_i,
  output logic             load_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [CNT_W-1:0] count_o
);
  import rx_cmd_pkg::*;

  gen_state_t       state_q, state_d;
  logic             done_q, done_d;
  logic             err_q, err_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             accept;

  assign accept = start_i && (state_q == ST_IDLE);
  assign load_o = accept && !len_zero_i;

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    err_d   = err_q;
    count_d = count_q;
    if (accept) begin
      count_d = cnt_i;
      err_d   = len_zero_i;
      if (len_zero_i) begin
        done_d = 1'b1;
      end else begin
        state_d = ST_SEND;
      end
    end else if ((state_q == ST_SEND) && hs_i && last_i) begin
      state_d = ST_IDLE;
      done_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      count_q <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      err_q   <= err_d;
      count_q <= count_d;
    end
  end

  assign busy_o  = (state_q == ST_SEND);
  assign done_o  = done_q;
  assign err_o   = err_q;
  assign count_o = count_q;
endmodule

// File: rtl/rx_cmd_gen.sv
module rx_cmd_gen #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned PAY_W  = 8,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = LEN_W - PAY_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic [CNT_W-1:0]  word_count_o,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [WORD_W-1:0] m_data_o,
  output logic              done_o,
  output logic              err_o
);
  logic             len_zero;
  logic [CNT_W-1:0] cnt_calc;
  logic             load;
  logic             hs;
  logic             last;
  logic [PAY_W-1:0] payload;

  assign len_zero = (len_i == '0);
  assign cnt_calc = {1'b0, len_i[LEN_W-1:PAY_W]} + CNT_W'(|len_i[PAY_W-1:0]);
  assign hs       = m_valid_o && m_ready_i;
  assign m_valid_o = busy_o;

  rx_cmd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .len_zero_i (len_zero),
    .cnt_i      (cnt_calc),
    .hs_i       (hs),
    .last_i     (last),
    .load_o     (load),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .count_o    (word_count_o)
  );

  rx_cmd_chunker #(.LEN_W(LEN_W), .PAY_W(PAY_W)) u_chunk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .len_i     (len_i),
    .step_i    (hs),
    .payload_o (payload),
    .last_o    (last)
  );

  rx_cmd_word_fmt #(.PAY_W(PAY_W), .WORD_W(WORD_W)) u_fmt (
    .payload_i (payload),
    .word_o    (m_data_o)
  );
endmodule

// File: rtl/rx_cmd_gen_chk.sv
module rx_cmd_gen_chk #(
  parameter int unsigned LEN_W  = 16,
  parameter int unsigned PAY_W  = 8,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [LEN_W-1:0]  len_i,
  input logic              busy_o,
  input logic [CNT_W-1:0]  word_count_o,
  input logic              m_valid_o,
  input logic              m_ready_i,
  input logic [WORD_W-1:0] m_data_o,
  input logic              done_o,
  input logic              err_o
);
  a_r1_word_format: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid_o |-> (m_data_o[10:8] == 3'b001) && (m_data_o[WORD_W-1:11] == '0));

  a_r5_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_data_o)));

  a_r3_short_is_last: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid_o && m_ready_i && (m_data_o[PAY_W-1:0] != '1)) |=> done_o);

  a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!m_valid_o && !busy_o));

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> (done_o && (word_count_o == '0)));

  a_r8_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(word_count_o));
endmodule

bind rx_cmd_gen rx_cmd_gen_chk #(
  .LEN_W(LEN_W), .PAY_W(PAY_W), .WORD_W(WORD_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .len_i        (len_i),
  .busy_o       (busy_o),
  .word_count_o (word_count_o),
  .m_valid_o    (m_valid_o),
  .m_ready_i    (m_ready_i),
  .m_data_o     (m_data_o),
  .done_o       (done_o),
  .err_o        (err_o)
);

// File: tb/rx_cmd_gen_bench.sv
module rx_cmd_gen_bench;
  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [15:0] len_i;
  logic        busy_o;
  logic [8:0]  word_count_o;
  logic        m_valid_o;
  logic        m_ready_i;
  logic [15:0] m_data_o;
  logic        done_o;
  logic        err_o;

  int n_checks = 0;
  int n_fail   = 0;

  rx_cmd_gen u_rx_cmd_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
    .busy_o(busy_o), .word_count_o(word_count_o), .m_valid_o(m_valid_o),
    .m_ready_i(m_ready_i), .m_data_o(m_data_o), .done_o(done_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int exp_count(input int n);
    return (n + 255) / 256;
  endfunction

  function automatic int exp_word(input int n, input int k);
    int rem;
    rem = n - 256 * k;
    return (1 << 8) | ((rem > 256) ? 255 : rem - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int n, input int rdy_pct, input bit poke);
    int nw;
    int k;
    int guard;
    bit hs;
    bit stall;
    logic [15:0] prev;
    nw = exp_count(n);
    @(negedge clk);
    start_i = 1'b1;
    len_i   = 16'(n);
    @(negedge clk);
    start_i = 1'b0;
    len_i   = 16'($urandom);
    if (n == 0) begin
      chk(done_o == 1'b1, "R7 done", int'(done_o), 1);
      chk(err_o == 1'b1, "R7 err", int'(err_o), 1);
      chk(m_valid_o == 1'b0, "R7 valid", int'(m_valid_o), 0);
      chk(word_count_o == 9'd0, "R7 count", int'(word_count_o), 0);
      @(negedge clk);
      chk(done_o == 1'b0, "R6 single pulse", int'(done_o), 0);
      chk(err_o == 1'b1, "R7 err held", int'(err_o), 1);
      return;
    end
    chk(busy_o == 1'b1, "R2 busy", int'(busy_o), 1);
    chk(err_o == 1'b0, "R7 err cleared", int'(err_o), 0);
    chk(int'(word_count_o) == nw, "R2 count", int'(word_count_o), nw);
    k = 0;
    stall = 1'b0;
    prev = '0;
    guard = 0;
    while (k < nw && guard < 20000) begin
      guard++;
      m_ready_i = (($urandom % 100) < rdy_pct);
      if (poke && k == 1) begin
        start_i = 1'b1;
        len_i   = 16'(($urandom % 4000) + 1);
      end else begin
        start_i = 1'b0;
      end
      if (stall)
        chk(m_valid_o && (m_data_o == prev), "R5 hold", int'(m_data_o), int'(prev));
      hs = m_valid_o && m_ready_i;
      if (hs) begin
        if (k < nw - 1)
          chk(int'(m_data_o) == exp_word(n, k), "R3 full chunk", int'(m_data_o), exp_word(n, k));
        else
          chk(int'(m_data_o) == exp_word(n, k), "R4 last word", int'(m_data_o), exp_word(n, k));
        chk(done_o == 1'b0, "R6 no early done", int'(done_o), 0);
      end
      stall = m_valid_o && !m_ready_i;
      prev  = m_data_o;
      @(negedge clk);
      if (hs) k++;
    end
    start_i   = 1'b0;
    m_ready_i = 1'b0;
    chk(done_o == 1'b1, "R6 done", int'(done_o), 1);
    chk(!m_valid_o && !busy_o, "R6 idle", int'({m_valid_o, busy_o}), 0);
    chk(int'(word_count_o) == nw, "R8 count kept", int'(word_count_o), nw);
    @(negedge clk);
    chk(done_o == 1'b0, "R6 single pulse", int'(done_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    start_i = 1'b0;
    len_i = '0;
    m_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(!m_valid_o && !done_o && !err_o && !busy_o && word_count_o == 0,
        "R9 reset", int'({m_valid_o, done_o, err_o, busy_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(int'(m_data_o[15:11]) == 0 && int'(m_data_o[10:8]) == 1, "R1 format",
        int'(m_data_o[15:8]), 1);
    run(0, 100, 1'b0);
    run(1, 100, 1'b0);
    run(255, 50, 1'b0);
    run(256, 100, 1'b0);
    run(257, 30, 1'b0);
    run(512, 70, 1'b1);
    run(513, 40, 1'b1);
    run(0, 100, 1'b0);
    run(65535, 90, 1'b0);
    for (int i = 0; i < 25; i++) begin
      run(int'(($urandom % 3000) + 1), int'(($urandom % 80) + 20), 1'(i % 2));
    end
    run(3000, 25, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule